// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with an 8-bit up counter that must be cleared, or "kicked", at regular intervals. A prescaler divides either the system clock or an external slow-clock tick. The counter advances by one on each divided source tick. Two select bits choose the division ratio, which sets the overflow period. Two further select bits define a legal kick window. The window is counted in quarters of the counter range, so that a kick that comes too early is rejected in the same way as one that never comes at all.

A detected malfunction is either a counter overflow from all-ones to zero or a kick outside the window. Its effect depends on a mode bit. In reset mode the block raises a reset request, which stays high until the block's own asynchronous reset is applied. In interrupt mode it sends a one-cycle non-maskable interrupt pulse and the counter keeps running. A low-power hold input freezes both the counter and the prescaler. Dropping the enable input forces both of them to zero.

All inputs are plain control pins that are sampled on the rising edge of `clk`. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `window_watchdog`

## Requirements
- R1: In fast mode (`slow_sel`=0), with `period_sel`=p, the counter advances once every 2^(FAST_LOG2+2p) enabled clock cycles. With the default FAST_LOG2 of 10, this spans four overflow periods, and each period is four times the previous one.
- R2: In slow mode (`slow_sel`=1), the prescaler advances only in cycles where `slow_tick` is high. The counter advances once every 2^(SLOW_LOG2+2p) such pulses.
- R3: When the counter wraps from 0xFF to 0x00, the selected detection output is asserted in the cycle after the wrapping edge. From a zeroed state, this happens on the 256th counter advance.
- R4: A kick is legal when the top two counter bits are greater than or equal to `win_sel`. With `win_sel` 00 a kick is legal at any count, with 01 from 0x40, with 10 from 0x80, and with 11 from 0xC0.
- R5: A legal kick clears the counter and the prescaler in the same edge and raises no output. It takes priority over a source tick in that cycle.
- R6: A kick outside the window raises the same detection output as an overflow, one cycle later. It leaves the counter and the prescaler unchanged.
- R7: With `alarm_rst_sel`=1, a detection sets `rst_req`. `rst_req` stays high through any later input activity until `rst_n` is asserted low.
- R8: With `alarm_rst_sel`=0, each detection produces a one-cycle `nmi_req` pulse. The counter keeps counting after an overflow, so the next overflow follows one full period later.
- R9: While `hold` is high, the counter and the prescaler keep their values. Counting resumes from those values when `hold` is released.
- R10: While `enable` is low, the counter and the prescaler stay at zero, and kicks are ignored with no output.
- R11: After reset, both outputs are low and the counter and the prescaler are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the only way to clear `rst_req` |
| slow_tick | input | 1 | One-cycle pulse, synchronous to `clk`, that marks a slow-clock period |
| slow_sel | input | 1 | 1: the prescaler counts `slow_tick` pulses; 0: it counts `clk` cycles |
| enable | input | 1 | Run enable; when low, the counter and the prescaler are held at zero |
| win_sel | input | 2 | Lower bound of the kick window, in quarters of the counter range |
| period_sel | input | 2 | Prescaler tap select that sets the overflow period |
| alarm_rst_sel | input | 1 | 1: a detection raises `rst_req`; 0: it pulses `nmi_req` |
| kick | input | 1 | Clear request, one cycle per kick |
| hold | input | 1 | Low-power hold; pauses all counting |
| rst_req | output | 1 | Sticky reset request |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk` and that `slow_tick` is a clean one-cycle pulse. They also assume that the configuration selects stay steady while the counter runs, because a tap change in the middle of a period has no defined tick spacing. The bench drives each input only on the falling clock edge. It changes `slow_sel`, `period_sel`, `win_sel` and `alarm_rst_sel` only in a cycle where `enable` is low, and it produces `slow_tick` as a one-cycle pulse followed by three idle cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    ALARM_NMI = 1'b0,
    ALARM_RST = 1'b1
  } alarm_mode_e;

  localparam int WIN_BITS    = 2;
  localparam int PERIOD_BITS = 2;
  localparam int PERIOD_STEP = 2;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int FAST_LOG2 = 10,
  parameter int SLOW_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       hold,
  input  logic       slow_sel,
  input  logic       slow_tick,
  input  logic [1:0] period_sel,
  input  logic       clr,
  output logic       src_tick
);
  localparam int MAX_BASE = (FAST_LOG2 > SLOW_LOG2) ? FAST_LOG2 : SLOW_LOG2;
  localparam int PRE_W    = MAX_BASE + wdt_pkg::PERIOD_STEP * 3;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] tap_mask;
  logic             step;
  int               tap;

  always_comb begin
    tap      = (slow_sel ? SLOW_LOG2 : FAST_LOG2) + wdt_pkg::PERIOD_STEP * int'(period_sel);
    tap_mask = (PRE_W'(1) << tap) - PRE_W'(1);
    step     = enable & ~hold & (slow_sel ? slow_tick : 1'b1);
    src_tick = step & ((pre_q & tap_mask) == tap_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!enable || clr) begin
      pre_q <= '0;
    end else if (step) begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/wdt_upcount.sv
module wdt_upcount #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             src_tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  assign ovf = src_tick & ~clr & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!enable || clr) begin
      cnt <= '0;
    end else if (src_tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_window.sv
module wdt_window (
  input  logic [wdt_pkg::WIN_BITS-1:0] cnt_top,
  input  logic [wdt_pkg::WIN_BITS-1:0] win_sel,
  input  logic                         enable,
  input  logic                         kick,
  output logic                         kick_ok,
  output logic                         kick_bad
);
  logic open_now;

  always_comb begin
    open_now = (cnt_top >= win_sel);
    kick_ok  = enable & kick & open_now;
    kick_bad = enable & kick & ~open_now;
  end
endmodule

// File: rtl/wdt_alarm.sv
module wdt_alarm (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt,
  input  wdt_pkg::alarm_mode_e mode,
  output logic                 rst_req,
  output logic                 nmi_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      nmi_req <= evt & (mode == wdt_pkg::ALARM_NMI);
      if (evt && mode == wdt_pkg::ALARM_RST) begin
        rst_req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int CNT_W     = 8,
  parameter int FAST_LOG2 = 10,
  parameter int SLOW_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       slow_sel,
  input  logic       enable,
  input  logic [1:0] win_sel,
  input  logic [1:0] period_sel,
  input  logic       alarm_rst_sel,
  input  logic       kick,
  input  logic       hold,
  output logic       rst_req,
  output logic       nmi_req
);
  localparam int TOP_W = wdt_pkg::WIN_BITS;

  logic [CNT_W-1:0]     cnt_q;
  logic                 src_tick;
  logic                 kick_ok;
  logic                 kick_bad;
  logic                 ovf_evt;
  logic                 alarm_evt;
  wdt_pkg::alarm_mode_e mode;

  assign mode      = wdt_pkg::alarm_mode_e'(alarm_rst_sel);
  assign alarm_evt = ovf_evt | kick_bad;

  wdt_prescaler #(
    .FAST_LOG2(FAST_LOG2),
    .SLOW_LOG2(SLOW_LOG2)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .hold      (hold),
    .slow_sel  (slow_sel),
    .slow_tick (slow_tick),
    .period_sel(period_sel),
    .clr       (kick_ok),
    .src_tick  (src_tick)
  );

  wdt_upcount #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .src_tick(src_tick),
    .clr     (kick_ok),
    .cnt     (cnt_q),
    .ovf     (ovf_evt)
  );

  wdt_window u_win (
    .cnt_top (cnt_q[CNT_W-1 -: TOP_W]),
    .win_sel (win_sel),
    .enable  (enable),
    .kick    (kick),
    .kick_ok (kick_ok),
    .kick_bad(kick_bad)
  );

  wdt_alarm u_alarm (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (alarm_evt),
    .mode   (mode),
    .rst_req(rst_req),
    .nmi_req(nmi_req)
  );
endmodule

// File: rtl/window_watchdog_chk.sv
module window_watchdog_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             hold,
  input logic             alarm_rst_sel,
  input logic [CNT_W-1:0] cnt,
  input logic             src_tick,
  input logic             kick_ok,
  input logic             kick_bad,
  input logic             ovf,
  input logic             rst_req,
  input logic             nmi_req
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && src_tick && !kick_ok) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_wrap_alarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (rst_req || nmi_req));

  assert_kick_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> cnt == '0);

  assert_bad_kick_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && kick_bad && !src_tick) |=> $stable(cnt));

  assert_rst_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  assert_rst_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf || kick_bad) && alarm_rst_sel) |=> rst_req);

  assert_nmi_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf || kick_bad) && !alarm_rst_sel) |=> nmi_req);

  assert_nmi_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> $past((ovf || kick_bad) && !alarm_rst_sel));

  assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hold && !kick_ok) |=> $stable(cnt));

  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !src_tick);

  assert_off_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cnt == '0);

  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!src_tick && !kick_ok && !kick_bad));
endmodule

bind window_watchdog window_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .hold         (hold),
  .alarm_rst_sel(alarm_rst_sel),
  .cnt          (cnt_q),
  .src_tick     (src_tick),
  .kick_ok      (kick_ok),
  .kick_bad     (kick_bad),
  .ovf          (ovf_evt),
  .rst_req      (rst_req),
  .nmi_req      (nmi_req)
);

// File: tb/window_watchdog_test.sv
module window_watchdog_test;
  localparam int FAST = 2;
  localparam int SLOW = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic       slow_sel = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] win_sel = 2'b00;
  logic [1:0] period_sel = 2'b00;
  logic       alarm_rst_sel = 1'b0;
  logic       kick = 1'b0;
  logic       hold = 1'b0;
  logic       rst_req;
  logic       nmi_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  window_watchdog #(.CNT_W(8), .FAST_LOG2(FAST), .SLOW_LOG2(SLOW)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .slow_sel(slow_sel),
    .enable(enable), .win_sel(win_sel), .period_sel(period_sel),
    .alarm_rst_sel(alarm_rst_sel), .kick(kick), .hold(hold),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic ssel, input logic [1:0] per,
                         input logic [1:0] win, input logic amode);
    @(negedge clk);
    enable = 1'b0; kick = 1'b0; hold = 1'b0; slow_tick = 1'b0;
    @(negedge clk);
    slow_sel = ssel; period_sel = per; win_sel = win; alarm_rst_sel = amode;
    enable = 1'b1;
  endtask

  task automatic wait_alarm(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (nmi_req || rst_req) break;
    end
  endtask

  task automatic kick_once();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 rst_req after reset", int'(rst_req), 0);
    chk("R11 nmi_req after reset", int'(nmi_req), 0);
  endtask

  task automatic t_fast(input logic [1:0] per);
    int n;
    int exp;
    exp = (1 << (FAST + 2 * int'(per))) * 256;
    restart(1'b0, per, 2'b00, 1'b0);
    wait_alarm(exp + 50, n);
    chk("R1 R3 cycles to first overflow", n, exp);
    chk("R8 nmi_req on overflow", int'(nmi_req), 1);
    chk("R7 rst_req stays low in nmi mode", int'(rst_req), 0);
    run(1);
    chk("R8 nmi_req pulse ends", int'(nmi_req), 0);
    wait_alarm(exp + 50, n);
    chk("R8 counter runs on to next overflow", n, exp - 1);
  endtask

  task automatic t_slow(input logic [1:0] per);
    int p;
    int exp;
    bit seen;
    exp = (1 << (SLOW + 2 * int'(per))) * 256;
    restart(1'b1, per, 2'b00, 1'b0);
    p = 0;
    seen = 0;
    while (!seen && p < exp + 8) begin
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      p++;
      if (nmi_req) seen = 1;
      else run(3);
    end
    chk("R2 slow pulses to overflow", p, exp);
  endtask

  task automatic t_window(input logic [1:0] w);
    int n;
    int b;
    int k;
    b = int'(w) * 64;
    if (w != 2'b00) begin
      k = (b - 1) * 4 + 2;
      restart(1'b0, 2'b00, w, 1'b0);
      run(k);
      kick_once();
      chk("R6 early kick raises nmi_req", int'(nmi_req), 1);
      run(1);
      chk("R6 early kick nmi pulse ends", int'(nmi_req), 0);
      wait_alarm(1100, n);
      chk("R6 early kick leaves count unchanged", n, 1024 - k - 2);
    end
    k = b * 4 + 2;
    restart(1'b0, 2'b00, w, 1'b0);
    run(k);
    kick_once();
    chk("R4 kick inside window silent", int'(nmi_req), 0);
    wait_alarm(1100, n);
    chk("R5 legal kick zeroes counter and prescaler", n, 1024);
  endtask

  task automatic t_hold();
    int n;
    restart(1'b0, 2'b00, 2'b00, 1'b0);
    run(100);
    hold = 1'b1;
    run(500);
    chk("R9 no alarm during hold", int'(nmi_req), 0);
    hold = 1'b0;
    wait_alarm(1100, n);
    chk("R9 count resumes from held value", n, 924);
  endtask

  task automatic t_disabled();
    int n;
    int hits;
    @(negedge clk);
    enable = 1'b0;
    hits = 0;
    for (int i = 0; i < 3000; i++) begin
      if (i == 1500) kick = 1'b1;
      else kick = 1'b0;
      @(negedge clk);
      if (nmi_req || rst_req) hits++;
    end
    kick = 1'b0;
    chk("R10 no output while disabled, kick ignored", hits, 0);
    restart(1'b0, 2'b00, 2'b11, 1'b0);
    wait_alarm(1100, n);
    chk("R10 counter held at zero while disabled", n, 1024);
  endtask

  task automatic t_reset_mode();
    int n;
    int nmi_hits;
    restart(1'b0, 2'b00, 2'b00, 1'b1);
    wait_alarm(1100, n);
    chk("R7 rst_req after overflow", int'(rst_req), 1);
    chk("R7 cycles to overflow in reset mode", n, 1024);
    nmi_hits = 0;
    enable = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (nmi_req) nmi_hits++;
    end
    chk("R7 rst_req sticky after disable", int'(rst_req), 1);
    chk("R7 no nmi_req in reset mode", nmi_hits, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R7 rst_req cleared by rst_n", int'(rst_req), 0);
    restart(1'b0, 2'b00, 2'b10, 1'b1);
    run(4 * 16);
    kick_once();
    chk("R6 R7 early kick sets rst_req", int'(rst_req), 1);
  endtask

  initial begin
    run(3);
    rst_n = 1'b1;
    run(1);
    t_reset();
    t_fast(2'b00);
    t_fast(2'b01);
    t_slow(2'b00);
    t_slow(2'b01);
    t_window(2'b00);
    t_window(2'b01);
    t_window(2'b10);
    t_window(2'b11);
    t_hold();
    t_disabled();
    t_reset_mode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule